// File: doc/BRIEF.md
# Debug Breakpoint and Halt Controller

This block is the halt logic inside the on-chip debugger of a small 8-bit microcontroller. A debug host loads up to four hardware breakpoints, each with a three-byte command. The block compares every enabled breakpoint with the CPU code address on every fetch. When one matches, it stops the CPU. The host can also stop the CPU with a halt request and restart it with a resume request.

A status byte tells the host four things: whether the CPU is halted, what caused the most recent halt, whether debug access is locked, and whether the CPU has written to the top byte of data memory (0xFF). That write is a likely sign that the stack has overflowed.

A configuration byte drives three outputs. One pauses DMA. One selects the flash information page. The third controls the timer count enable, using two bits: a hard timer-off bit, and a softer suspend bit that acts only during debug instructions and stepped branches.

Everything runs on one clock with a synchronous active-high reset.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A breakpoint load is three bytes. The first byte is marked by `bp_byte_first`, and its fields are: bits [7:6] slot index, bit 5 enable, bits [1:0] address bits 17:16. The second byte carries address bits 15:8 and the third carries bits 7:0. The slot takes the new value one cycle after the third byte is accepted.
- R2: While the CPU runs, a fetch (`cpu_addr_valid`=1) whose address equals an enabled slot's address halts the CPU at the next clock edge. After that edge, status bit 5 is 1 and status bit 3 is 1.
- R3: A slot whose enable bit is 0 never causes a halt, whatever its stored address.
- R4: A halt request while the CPU runs halts it at the next edge, with status bit 3 = 0.
- R5: A resume request while halted clears the halted state at the next edge, and status bit 3 keeps its value. While halted, breakpoint matches and halt requests are ignored. While running, a resume request has no effect.
- R6: If a breakpoint match and a halt request arrive in the same cycle, the halt cause is recorded as breakpoint (bit 3 = 1).
- R7: A data write to address 0xFF sets status bit 0, and it stays set until reset or a `status_clr` pulse. If the write and the clear arrive in the same cycle, the flag ends up set.
- R8: A configuration write stores data bits 3:0 and reads back bits 7:4 as zero. Bit 2 drives `dma_pause` and bit 0 drives `flash_info_sel`.
- R9: `timer_run_en` is 0 whenever configuration bit 3 (timers off) is 1. Otherwise it is 0 while bit 1 (suspend) is 1 and either `dbg_instr_active` or `step_branch` is high. In all other cases it is 1. The output follows these inputs in the same cycle.
- R10: Status bit 2 shows the value `lock_in` had on the previous clock edge. Status bits 7, 6, 4 and 1 read as zero.
- R11: After reset the CPU is not halted, status bits 5, 3 and 0 are 0, the configuration byte is 0, and all slots are disabled.
- R12: A byte not marked first is ignored when no load is in progress. A byte marked first always restarts the load sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_byte_valid | input | 1 | Breakpoint command byte strobe |
| bp_byte_first | input | 1 | Marks the first byte of a load |
| bp_byte | input | 8 | Breakpoint command byte |
| cpu_addr | input | 18 | CPU code address |
| cpu_addr_valid | input | 1 | Code address is a real fetch |
| halt_req | input | 1 | Halt request from the debug host |
| resume_req | input | 1 | Resume request from the debug host |
| dmem_wr_en | input | 1 | CPU data memory write strobe |
| dmem_wr_addr | input | 8 | CPU data memory write address |
| lock_in | input | 1 | Debug lock state |
| status_clr | input | 1 | Clears the stack-overflow flag |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| dbg_instr_active | input | 1 | A debug instruction is executing |
| step_branch | input | 1 | The stepped instruction is a branch |
| cpu_halted | output | 1 | CPU halt request to the core |
| status_q | output | 8 | Status byte |
| cfg_q | output | 8 | Configuration byte |
| dma_pause | output | 1 | Pause all DMA transfers |
| flash_info_sel | output | 1 | Select the flash information page |
| timer_run_en | output | 1 | Timer count enable |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- A breakpoint match in the same cycle as a halt request. A design with the wrong priority would record the command as the cause.
- Matches and halt requests that arrive while already halted. A design that let them through would overwrite the recorded cause.
- A stray second byte with no load in progress, and a first byte that restarts a load part-way through. A loose loader would write a wrong address or the wrong slot.
- Timers off combined with suspend. A design that put suspend first would let the timer run.
- A stack-overflow write in the same cycle as a clear. A design that let the clear win would lose the event.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int BP_ADDR_W   = 18;
  localparam int BP_NUM      = 4;
  localparam int BP_SLOT_W   = 2;
  localparam int CMD_BYTES   = 3;
  localparam int CFG_USED_W  = 4;

  // configuration bit positions
  localparam int CFG_TOFF    = 3;
  localparam int CFG_DMA     = 2;
  localparam int CFG_SUSP    = 1;
  localparam int CFG_FLASH   = 0;

  // status bit positions
  localparam int ST_HALTED   = 5;
  localparam int ST_CAUSE    = 3;
  localparam int ST_LOCK     = 2;
  localparam int ST_OVF      = 0;

  typedef struct packed {
    logic                 en;
    logic [BP_ADDR_W-1:0] addr;
  } bp_slot_t;
endpackage

// File: rtl/dbg_bp_loader.sv
module dbg_bp_loader
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = BP_ADDR_W,
  parameter int SLOT_W = BP_SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic              byte_first,
  input  logic [7:0]        byte_in,
  output logic              wr_stb,
  output logic [SLOT_W-1:0] wr_slot,
  output bp_slot_t          wr_val
);
  localparam int CNT_W  = $clog2(CMD_BYTES);
  localparam int FULL_W = 18;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hdr_q;
  logic [7:0]       mid_q;
  logic [FULL_W-1:0] full_addr;

  assign full_addr = {hdr_q[1:0], mid_q, byte_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      hdr_q   <= '0;
      mid_q   <= '0;
      wr_stb  <= 1'b0;
      wr_slot <= '0;
      wr_val  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (byte_valid) begin
        if (byte_first) begin
          hdr_q <= byte_in;
          cnt_q <= CNT_W'(1);
        end else if (cnt_q == CNT_W'(1)) begin
          mid_q <= byte_in;
          cnt_q <= CNT_W'(2);
        end else if (cnt_q == CNT_W'(2)) begin
          wr_stb      <= 1'b1;
          wr_slot     <= hdr_q[7 -: SLOT_W];
          wr_val.en   <= hdr_q[5];
          wr_val.addr <= full_addr[ADDR_W-1:0];
          cnt_q       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_bp_bank.sv
module dbg_bp_bank
  import dbg_halt_pkg::*;
#(
  parameter int NUM    = BP_NUM,
  parameter int ADDR_W = BP_ADDR_W,
  parameter int SLOT_W = BP_SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [SLOT_W-1:0] wr_slot,
  input  bp_slot_t          wr_val,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              hit
);
  logic [NUM-1:0] hit_vec;

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    bp_slot_t slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (wr_stb && (wr_slot == SLOT_W'(g))) begin
        slot_q <= wr_val;
      end
    end
    assign hit_vec[g] = slot_q.en && (slot_q.addr == cmp_addr);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/dbg_halt_core.sv
module dbg_halt_core
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bp_hit,
  input  logic       fetch_valid,
  input  logic       halt_req,
  input  logic       resume_req,
  input  logic       dmem_wr_en,
  input  logic [7:0] dmem_wr_addr,
  input  logic       lock_in,
  input  logic       status_clr,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_wr_data,
  input  logic       dbg_instr_active,
  input  logic       step_branch,
  output logic       halted,
  output logic [7:0] status,
  output logic [7:0] cfg,
  output logic       timer_en
);
  localparam logic [7:0] TOP_DATA_ADDR = 8'hFF;

  logic                  halted_q;
  logic                  cause_q;
  logic                  lock_q;
  logic                  ovf_q;
  logic [CFG_USED_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      cause_q  <= 1'b0;
    end else if (halted_q) begin
      if (resume_req) halted_q <= 1'b0;
    end else if (fetch_valid && bp_hit) begin
      halted_q <= 1'b1;
      cause_q  <= 1'b1;
    end else if (halt_req) begin
      halted_q <= 1'b1;
      cause_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q  <= 1'b0;
      lock_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      lock_q <= lock_in;
      if (dmem_wr_en && (dmem_wr_addr == TOP_DATA_ADDR)) ovf_q <= 1'b1;
      else if (status_clr) ovf_q <= 1'b0;
      if (cfg_wr_en) cfg_q <= cfg_wr_data[CFG_USED_W-1:0];
    end
  end

  always_comb begin
    status            = '0;
    status[ST_HALTED] = halted_q;
    status[ST_CAUSE]  = cause_q;
    status[ST_LOCK]   = lock_q;
    status[ST_OVF]    = ovf_q;
  end

  assign cfg      = {{(8-CFG_USED_W){1'b0}}, cfg_q};
  assign halted   = halted_q;
  assign timer_en = !cfg_q[CFG_TOFF] &&
                    !(cfg_q[CFG_SUSP] && (dbg_instr_active || step_branch));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int NUM_BP = BP_NUM,
  parameter int ADDR_W = BP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bp_byte_valid,
  input  logic              bp_byte_first,
  input  logic [7:0]        bp_byte,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_addr_valid,
  input  logic              halt_req,
  input  logic              resume_req,
  input  logic              dmem_wr_en,
  input  logic [7:0]        dmem_wr_addr,
  input  logic              lock_in,
  input  logic              status_clr,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_data,
  input  logic              dbg_instr_active,
  input  logic              step_branch,
  output logic              cpu_halted,
  output logic [7:0]        status_q,
  output logic [7:0]        cfg_q,
  output logic              dma_pause,
  output logic              flash_info_sel,
  output logic              timer_run_en
);
  localparam int SLOT_W = BP_SLOT_W;

  logic              ld_stb;
  logic [SLOT_W-1:0] ld_slot;
  bp_slot_t          ld_val;
  logic              bp_hit;

  dbg_bp_loader #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_loader (
    .clk(clk), .rst(rst),
    .byte_valid(bp_byte_valid), .byte_first(bp_byte_first), .byte_in(bp_byte),
    .wr_stb(ld_stb), .wr_slot(ld_slot), .wr_val(ld_val)
  );

  dbg_bp_bank #(.NUM(NUM_BP), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_stb(ld_stb), .wr_slot(ld_slot), .wr_val(ld_val),
    .cmp_addr(cpu_addr), .hit(bp_hit)
  );

  dbg_halt_core u_core (
    .clk(clk), .rst(rst),
    .bp_hit(bp_hit), .fetch_valid(cpu_addr_valid),
    .halt_req(halt_req), .resume_req(resume_req),
    .dmem_wr_en(dmem_wr_en), .dmem_wr_addr(dmem_wr_addr),
    .lock_in(lock_in), .status_clr(status_clr),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .dbg_instr_active(dbg_instr_active), .step_branch(step_branch),
    .halted(cpu_halted), .status(status_q), .cfg(cfg_q), .timer_en(timer_run_en)
  );

  assign dma_pause      = cfg_q[CFG_DMA];
  assign flash_info_sel = cfg_q[CFG_FLASH];
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bp_hit,
  input logic       cpu_addr_valid,
  input logic       halt_req,
  input logic       resume_req,
  input logic       cpu_halted,
  input logic [7:0] status_q,
  input logic [7:0] cfg_q,
  input logic       dmem_wr_en,
  input logic [7:0] dmem_wr_addr,
  input logic       status_clr,
  input logic       timer_run_en
);
  assert_bp_halt_R2: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halted && cpu_addr_valid && bp_hit) |=> (cpu_halted && status_q[3]));

  assert_cmd_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halted && halt_req && !(cpu_addr_valid && bp_hit)) |=> (cpu_halted && !status_q[3]));

  assert_resume_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_halted && resume_req) |=> !cpu_halted);

  assert_cause_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_halted || !(halt_req || (cpu_addr_valid && bp_hit))) |=> $stable(status_q[3]));

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    (dmem_wr_en && dmem_wr_addr == 8'hFF) |=> status_q[0]);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && !status_clr) |=> status_q[0]);

  assert_cfg_upper_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_q[7:4] == 4'h0);

  assert_timer_off_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_q[3] |-> !timer_run_en);

  assert_halt_mirror_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_halted == status_q[5]) && (status_q[7:6] == 2'b00) && !status_q[4] && !status_q[1]);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bp_hit(bp_hit), .cpu_addr_valid(cpu_addr_valid),
  .halt_req(halt_req), .resume_req(resume_req), .cpu_halted(cpu_halted),
  .status_q(status_q), .cfg_q(cfg_q), .dmem_wr_en(dmem_wr_en),
  .dmem_wr_addr(dmem_wr_addr), .status_clr(status_clr), .timer_run_en(timer_run_en)
);

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        bp_byte_valid, bp_byte_first;
  logic [7:0]  bp_byte;
  logic [17:0] cpu_addr;
  logic        cpu_addr_valid, halt_req, resume_req;
  logic        dmem_wr_en;
  logic [7:0]  dmem_wr_addr;
  logic        lock_in, status_clr, cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic        dbg_instr_active, step_branch;
  logic        cpu_halted, dma_pause, flash_info_sel, timer_run_en;
  logic [7:0]  status_q, cfg_q;

  int checks = 0;
  int errors = 0;

  dbg_halt_ctrl u_dbg_halt_ctrl (.*);

  always #5 clk = ~clk;

  // reference model state
  logic        m_en   [4];
  logic [17:0] m_addr [4];
  logic        m_halt, m_cause, m_ovf, m_lock;
  logic [3:0]  m_cfg;
  int          ld_cnt;
  logic [7:0]  ld_b0, ld_b1;
  logic        pend, pend_en;
  logic [1:0]  pend_slot;
  logic [17:0] pend_addr;

  function automatic logic [7:0] exp_status();
    return {2'b00, m_halt, 1'b0, m_cause, m_lock, 1'b0, m_ovf};
  endfunction

  function automatic logic exp_timer();
    return !m_cfg[3] && !(m_cfg[1] && (dbg_instr_active || step_branch));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_addr[i] = '0; end
    m_halt = 0; m_cause = 0; m_ovf = 0; m_lock = 0; m_cfg = '0;
    ld_cnt = 0; ld_b0 = '0; ld_b1 = '0; pend = 0; pend_en = 0; pend_slot = '0; pend_addr = '0;
  endtask

  task automatic model_step();
    logic hit = 0;
    if (rst) begin model_reset(); return; end
    for (int i = 0; i < 4; i++) if (m_en[i] && m_addr[i] == cpu_addr) hit = 1;
    if (m_halt) begin
      if (resume_req) m_halt = 0;
    end else if (cpu_addr_valid && hit) begin
      m_halt = 1; m_cause = 1;
    end else if (halt_req) begin
      m_halt = 1; m_cause = 0;
    end
    if (dmem_wr_en && dmem_wr_addr == 8'hFF) m_ovf = 1;
    else if (status_clr) m_ovf = 0;
    m_lock = lock_in;
    if (cfg_wr_en) m_cfg = cfg_wr_data[3:0];
    if (pend) begin
      m_en[pend_slot] = pend_en; m_addr[pend_slot] = pend_addr; pend = 0;
    end
    if (bp_byte_valid) begin
      if (bp_byte_first) begin ld_b0 = bp_byte; ld_cnt = 1; end
      else if (ld_cnt == 1) begin ld_b1 = bp_byte; ld_cnt = 2; end
      else if (ld_cnt == 2) begin
        pend = 1; pend_slot = ld_b0[7:6]; pend_en = ld_b0[5];
        pend_addr = {ld_b0[1:0], ld_b1, bp_byte}; ld_cnt = 0;
      end
    end
  endtask

  task automatic idle();
    bp_byte_valid = 0; bp_byte_first = 0; bp_byte = '0;
    cpu_addr_valid = 0; halt_req = 0; resume_req = 0;
    dmem_wr_en = 0; dmem_wr_addr = '0; status_clr = 0;
    cfg_wr_en = 0; cfg_wr_data = '0; dbg_instr_active = 0; step_branch = 0;
  endtask

  // inputs set after a negedge; runs one clock and compares registered outputs
  task automatic cycle();
    #1;
    check("R9 timer enable", timer_run_en, exp_timer());
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2 R3 R4 R5 R6 R7 R10 status", status_q, exp_status());
    check("R2 R4 R5 halted", cpu_halted, m_halt);
    check("R8 cfg", cfg_q, {4'h0, m_cfg});
    check("R8 dma/flash", {dma_pause, flash_info_sel}, {m_cfg[2], m_cfg[0]});
  endtask

  task automatic send_byte(logic first, logic [7:0] b);
    idle(); bp_byte_valid = 1; bp_byte_first = first; bp_byte = b;
    cycle();
  endtask

  task automatic load_bp(logic [1:0] slot, logic en, logic [17:0] a);
    send_byte(1, {slot, en, 3'b000, a[17:16]});
    send_byte(0, a[15:8]);
    send_byte(0, a[7:0]);
    idle(); cycle();
  endtask

  task automatic fetch(logic [17:0] a);
    idle(); cpu_addr_valid = 1; cpu_addr = a; cycle();
  endtask

  task automatic resume();
    idle(); resume_req = 1; cycle();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(); cpu_addr = '0; lock_in = 0; rst = 1;
    model_reset();
    @(negedge clk); cycle(); cycle();
    rst = 0;
    @(negedge clk);
    check("R11 reset status", status_q, 8'h00);
    check("R11 reset cfg", cfg_q, 8'h00);
    check("R11 reset halted", cpu_halted, 1'b0);

    // R11/R3: all slots disabled after reset, address 0 must not halt
    fetch(18'h0);
    check("R11 no halt at reset slots", cpu_halted, 1'b0);

    // R1/R2: load slot 2 and hit it
    load_bp(2'd2, 1'b1, 18'h2_A5C3);
    fetch(18'h2_A5C2);
    check("R2 near miss", cpu_halted, 1'b0);
    fetch(18'h2_A5C3);
    check("R2 bp halt", status_q[5:3], 3'b101);
    // R5: fetch/halt request while halted ignored
    idle(); halt_req = 1; cycle();
    check("R5 cause kept while halted", status_q[3], 1'b1);
    resume();
    check("R5 resumed", cpu_halted, 1'b0);
    check("R5 cause held", status_q[3], 1'b1);
    resume();
    check("R5 resume while running", cpu_halted, 1'b0);

    // R3: disabled slot with matching address
    load_bp(2'd1, 1'b0, 18'h0_1234);
    fetch(18'h0_1234);
    check("R3 disabled slot", cpu_halted, 1'b0);

    // R4: halt command
    idle(); halt_req = 1; cycle();
    check("R4 cmd halt", status_q[5:3], 3'b100);
    resume();

    // R6: both same cycle
    idle(); halt_req = 1; cpu_addr_valid = 1; cpu_addr = 18'h2_A5C3; cycle();
    check("R6 bp wins", status_q[3], 1'b1);
    resume();

    // R12: stray byte then restart mid-sequence
    send_byte(0, 8'hFF);
    send_byte(1, {2'd3, 1'b1, 5'b00001});
    send_byte(0, 8'h77);
    send_byte(1, {2'd0, 1'b1, 5'b00011});
    send_byte(0, 8'h10);
    send_byte(0, 8'h20);
    idle(); cycle();
    fetch(18'h1_7700);
    check("R12 aborted load not written", cpu_halted, 1'b0);
    fetch(18'h3_1020);
    check("R12 restarted load", cpu_halted, 1'b1);
    resume();

    // R7: overflow set+clear same cycle, then clear
    idle(); dmem_wr_en = 1; dmem_wr_addr = 8'hFF; status_clr = 1; cycle();
    check("R7 set beats clear", status_q[0], 1'b1);
    idle(); dmem_wr_en = 1; dmem_wr_addr = 8'hFE; cycle();
    check("R7 sticky", status_q[0], 1'b1);
    idle(); status_clr = 1; cycle();
    check("R7 cleared", status_q[0], 1'b0);

    // R8/R9: config corner cases
    idle(); cfg_wr_en = 1; cfg_wr_data = 8'hFA; cycle();
    check("R8 upper zero", cfg_q, 8'h0A);
    idle(); dbg_instr_active = 0; #1;
    check("R9 timers off overrides", timer_run_en, 1'b0);
    cycle();
    idle(); cfg_wr_en = 1; cfg_wr_data = 8'h02; cycle();
    idle(); step_branch = 1; #1;
    check("R9 suspend on branch", timer_run_en, 1'b0);
    cycle();
    idle(); #1;
    check("R9 suspend idle runs", timer_run_en, 1'b1);
    cycle();

    // R10: lock mirror
    lock_in = 1; idle(); cycle();
    check("R10 lock bit", status_q[2], 1'b1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      idle();
      r = $urandom_range(0, 99);
      if (r < 6) begin
        load_bp(2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0),
                18'h1_0000 + 18'($urandom_range(0, 15)));
      end else begin
        cpu_addr       = 18'h1_0000 + 18'($urandom_range(0, 31));
        cpu_addr_valid = 1'($urandom_range(0, 1));
        halt_req       = ($urandom_range(0, 19) == 0);
        resume_req     = ($urandom_range(0, 3) == 0);
        dmem_wr_en     = ($urandom_range(0, 7) == 0);
        dmem_wr_addr   = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom);
        status_clr     = ($urandom_range(0, 9) == 0);
        cfg_wr_en      = ($urandom_range(0, 15) == 0);
        cfg_wr_data    = 8'($urandom);
        dbg_instr_active = 1'($urandom_range(0, 1));
        step_branch    = 1'($urandom_range(0, 1));
        lock_in        = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 9) == 0) begin
          bp_byte_valid = 1; bp_byte_first = 1'($urandom_range(0, 1)); bp_byte = 8'($urandom);
        end
        cycle();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule